// File: doc/BRIEF.md
# Bus Access Fault Monitor

This block observes every bus cycle for four kinds of fault: a watchdog timeout, a read aimed at a region that only accepts writes, an error reported by the external transfer-error input, and a user-mode access to a region reserved for supervisor code. Each fault has a sticky flag and an enable bit in one status/enable word. A flag is always recorded when its fault occurs. The enable bit only decides whether the cycle in which the fault was seen ends with an access error.

A bus cycle is framed by `cyc_active`, which is high for every clock of the cycle, and `cyc_done`, which is high for the clock in which the cycle terminates. Region attributes come from an address decoder outside this block and must be valid on the terminating clock. If the external error or the watchdog pulse arrives on any clock of the cycle, it is held until the termination. Software clears a flag by writing 1 to it and sets the enables directly. Writes are accepted only from supervisor mode.

Top module: `bus_fault_mon`

## Requirements
- R1: After reset the whole register word reads 0. Bits 7..4 and every bit above 11 always read 0.
- R2: A read (`cyc_write`=0) that terminates with `rgn_hit`=1 and `rgn_wo`=1 sets the read-protect flag at bit 10 on that clock edge.
- R3: An access in user mode (`cyc_super`=0) that terminates with `rgn_hit`=1 and `rgn_so`=1 sets the privilege flag at bit 8.
- R4: If `xfer_err` is high on any clock of a cycle, up to and including its terminating clock, the external-error flag at bit 9 is set at the termination. `xfer_err` is ignored outside a cycle.
- R5: A `wdt_tmo` pulse sets the watchdog flag at bit 11 on the next clock edge, whether or not a cycle is in progress.
- R6: On a terminating clock, `access_err` is the OR, over the four sources detected in that cycle, of source-detected AND enable. The enables sit at bit 3 (watchdog), bit 2 (read-protect), bit 1 (external) and bit 0 (privilege). A watchdog pulse counts for a cycle if it came while the cycle was active.
- R7: A flag is recorded even when its enable is clear. In that case the cycle ends with `access_err`=0.
- R8: A supervisor write with 1 in a flag bit clears that flag. Writing 0 to a flag leaves it unchanged.
- R9: If a fault event and a clearing write for the same flag fall on the same clock, the flag stays set.
- R10: A supervisor write loads bits 3..0 into the enables. These bits read back unchanged.
- R11: A write with `reg_super`=0 changes no flag and no enable.
- R12: `access_err` is high only on clocks where `cyc_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_active | input | 1 | High on every clock of a bus cycle |
| cyc_done | input | 1 | Termination strobe, last clock of the cycle |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_super | input | 1 | 1 = supervisor access, 0 = user access |
| rgn_hit | input | 1 | Address matched a chip-select region |
| rgn_wo | input | 1 | Matched region is write-only |
| rgn_so | input | 1 | Matched region is supervisor-only |
| xfer_err | input | 1 | External transfer-error report |
| wdt_tmo | input | 1 | Watchdog timeout pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_super | input | 1 | Privilege of the register write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Status/enable word |
| access_err | output | 1 | Terminate current cycle with access error |

## Verification
On every cycle the assertions check several rules. A fault event always leaves its flag set on the next edge. A flag with no event and no clearing write stays set. A supervisor 1-write with no event clears the flag. User-mode writes leave the enables stable. `access_err` only appears on terminating clocks and only when some enable is set. The unused bits stay zero. Other behaviour only shows up in the bench's scenarios: an external error held across a multi-clock cycle, a watchdog pulse that lands inside a cycle and is counted at its end, and the exact per-source OR of enabled faults against a model.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  localparam int NSRC     = 4;
  localparam int FLAG_LSB = 8;   // flags occupy bits 11..8
  localparam int EN_LSB   = 0;   // enables occupy bits 3..0
  localparam int USED_MSB = FLAG_LSB + NSRC - 1;

  // Source index; index k maps to flag bit FLAG_LSB+k and enable bit EN_LSB+k
  typedef enum logic [1:0] {
    SRC_PRIV = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_RDP  = 2'd2,
    SRC_WDT  = 2'd3
  } fault_src_e;

  // Sticky flag update: an event always wins over a clear
  function automatic logic [NSRC-1:0] flag_next(input logic [NSRC-1:0] cur,
                                                input logic [NSRC-1:0] evt,
                                                input logic [NSRC-1:0] clr);
    return (cur & ~clr) | evt;
  endfunction

  // Per-source abort qualification
  function automatic logic src_abort(input logic seen, input logic en);
    return seen & en;
  endfunction
endpackage

// File: rtl/bfm_detect.sv
module bfm_detect
  import bfm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_active,
  input  logic            cyc_done,
  input  logic            cyc_write,
  input  logic            cyc_super,
  input  logic            rgn_hit,
  input  logic            rgn_wo,
  input  logic            rgn_so,
  input  logic            xfer_err,
  input  logic            wdt_tmo,
  output logic [NSRC-1:0] evt_now,   // flag-set events on this clock
  output logic [NSRC-1:0] cyc_src    // sources seen by the terminating cycle
);
  logic ext_pend_q;
  logic wdt_pend_q;
  logic rdp_hit;
  logic priv_hit;
  logic ext_seen;
  logic wdt_seen;

  // Hold errors that arrive before the termination strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_pend_q <= 1'b0;
      wdt_pend_q <= 1'b0;
    end else if (cyc_done) begin
      ext_pend_q <= 1'b0;
      wdt_pend_q <= 1'b0;
    end else if (cyc_active) begin
      if (xfer_err) ext_pend_q <= 1'b1;
      if (wdt_tmo)  wdt_pend_q <= 1'b1;
    end
  end

  always_comb begin
    rdp_hit  = cyc_done & rgn_hit & ~cyc_write & rgn_wo;
    priv_hit = cyc_done & rgn_hit & ~cyc_super & rgn_so;
    ext_seen = cyc_done & (ext_pend_q | xfer_err);
    wdt_seen = cyc_done & (wdt_pend_q | wdt_tmo);
  end

  always_comb begin
    evt_now           = '0;
    evt_now[SRC_PRIV] = priv_hit;
    evt_now[SRC_EXT]  = ext_seen;
    evt_now[SRC_RDP]  = rdp_hit;
    evt_now[SRC_WDT]  = wdt_tmo;
    cyc_src           = evt_now;
    cyc_src[SRC_WDT]  = wdt_seen;
  end
endmodule

// File: rtl/bfm_status.sv
module bfm_status
  import bfm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ok,
  input  logic [NSRC-1:0] wr_flag_bits,
  input  logic [NSRC-1:0] wr_en_bits,
  input  logic [NSRC-1:0] evt_now,
  output logic [NSRC-1:0] flags_q,
  output logic [NSRC-1:0] enables_q
);
  logic [NSRC-1:0] clr_mask;

  assign clr_mask = wr_ok ? wr_flag_bits : '0;

  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    logic nxt_flag;
    always_comb begin
      nxt_flag = flag_next(flags_q, evt_now, clr_mask)[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[k]   <= 1'b0;
        enables_q[k] <= 1'b0;
      end else begin
        flags_q[k] <= nxt_flag;
        if (wr_ok) enables_q[k] <= wr_en_bits[k];
      end
    end
  end
endmodule

// File: rtl/bfm_abort.sv
module bfm_abort
  import bfm_pkg::*;
(
  input  logic [NSRC-1:0] cyc_src,
  input  logic [NSRC-1:0] enables_q,
  output logic            access_err
);
  logic [NSRC-1:0] per_src;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign per_src[k] = src_abort(cyc_src[k], enables_q[k]);
  end

  assign access_err = |per_src;
endmodule

// File: rtl/bus_fault_mon.sv
module bus_fault_mon
  import bfm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_active,
  input  logic              cyc_done,
  input  logic              cyc_write,
  input  logic              cyc_super,
  input  logic              rgn_hit,
  input  logic              rgn_wo,
  input  logic              rgn_so,
  input  logic              xfer_err,
  input  logic              wdt_tmo,
  input  logic              reg_wr,
  input  logic              reg_super,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              access_err
);
  logic [NSRC-1:0] evt_now;
  logic [NSRC-1:0] cyc_src;
  logic [NSRC-1:0] flags_q;
  logic [NSRC-1:0] enables_q;
  logic            wr_ok;
  logic            unused_wdata_bits;

  assign wr_ok             = reg_wr & reg_super;
  assign unused_wdata_bits = ^{reg_wdata[DATA_W-1:USED_MSB+1],
                               reg_wdata[FLAG_LSB-1:EN_LSB+NSRC]};

  bfm_detect u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_active (cyc_active),
    .cyc_done   (cyc_done),
    .cyc_write  (cyc_write),
    .cyc_super  (cyc_super),
    .rgn_hit    (rgn_hit),
    .rgn_wo     (rgn_wo),
    .rgn_so     (rgn_so),
    .xfer_err   (xfer_err),
    .wdt_tmo    (wdt_tmo),
    .evt_now    (evt_now),
    .cyc_src    (cyc_src)
  );

  bfm_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ok        (wr_ok),
    .wr_flag_bits (reg_wdata[FLAG_LSB +: NSRC]),
    .wr_en_bits   (reg_wdata[EN_LSB +: NSRC]),
    .evt_now      (evt_now),
    .flags_q      (flags_q),
    .enables_q    (enables_q)
  );

  bfm_abort u_abort (
    .cyc_src    (cyc_src),
    .enables_q  (enables_q),
    .access_err (access_err)
  );

  always_comb begin
    reg_rdata                      = '0;
    reg_rdata[FLAG_LSB +: NSRC]    = flags_q;
    reg_rdata[EN_LSB +: NSRC]      = enables_q;
  end
endmodule

// File: rtl/bfm_checker.sv
module bfm_checker
  import bfm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_done,
  input logic              reg_wr,
  input logic              reg_super,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              access_err,
  input logic [NSRC-1:0]   evt_now
);
  // R12
  err_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> cyc_done);

  // R6
  err_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> (reg_rdata[EN_LSB +: NSRC] != '0));

  // R1
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DATA_W-1:USED_MSB+1] == '0) && (reg_rdata[FLAG_LSB-1:EN_LSB+NSRC] == '0));

  // R11
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_super) |=> $stable(reg_rdata[EN_LSB +: NSRC]));

  for (genvar k = 0; k < NSRC; k++) begin : g_flag
    // R9
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_now[k] |=> reg_rdata[FLAG_LSB+k]);

    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_super && reg_wdata[FLAG_LSB+k] && !evt_now[k]) |=> !reg_rdata[FLAG_LSB+k]);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[FLAG_LSB+k] && !(reg_wr && reg_super && reg_wdata[FLAG_LSB+k]))
        |=> reg_rdata[FLAG_LSB+k]);
  end
endmodule

bind bus_fault_mon bfm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_done   (cyc_done),
  .reg_wr     (reg_wr),
  .reg_super  (reg_super),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .access_err (access_err),
  .evt_now    (evt_now)
);

// File: tb/bus_fault_mon_tb_top.sv
module bus_fault_mon_tb_top;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_active = 0, cyc_done = 0, cyc_write = 0, cyc_super = 0;
  logic rgn_hit = 0, rgn_wo = 0, rgn_so = 0, xfer_err = 0, wdt_tmo = 0;
  logic reg_wr = 0, reg_super = 0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic access_err;

  int n_checks = 0;
  int n_fail = 0;
  int cyc_count = 0;

  // model state: flags W,R,E,P and enables W,R,E,P
  logic fw = 0, fr = 0, fe = 0, fp = 0;
  logic ew = 0, er = 0, ee = 0, ep = 0;
  logic m_ext = 0, m_wdt = 0;

  always #2 clk = ~clk;   // 250 MHz

  bus_fault_mon #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_active(cyc_active), .cyc_done(cyc_done),
    .cyc_write(cyc_write), .cyc_super(cyc_super), .rgn_hit(rgn_hit),
    .rgn_wo(rgn_wo), .rgn_so(rgn_so), .xfer_err(xfer_err), .wdt_tmo(wdt_tmo),
    .reg_wr(reg_wr), .reg_super(reg_super), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .access_err(access_err)
  );

  function automatic logic [DW-1:0] model_word();
    logic [DW-1:0] w = '0;
    w[11] = fw; w[10] = fr; w[9] = fe; w[8] = fp;
    w[3]  = ew; w[2]  = er; w[1] = ee; w[0] = ep;
    return w;
  endfunction

  function automatic logic model_err();
    logic s_w, s_r, s_e, s_p;
    if (!cyc_done) return 1'b0;
    s_w = m_wdt || wdt_tmo;
    s_e = m_ext || xfer_err;
    s_r = rgn_hit && rgn_wo && !cyc_write;
    s_p = rgn_hit && rgn_so && !cyc_super;
    return (s_w && ew) || (s_r && er) || (s_e && ee) || (s_p && ep);
  endfunction

  task automatic model_update();
    logic wok;
    logic e_r, e_p, e_e;
    wok = reg_wr && reg_super;
    e_r = cyc_done && rgn_hit && rgn_wo && !cyc_write;
    e_p = cyc_done && rgn_hit && rgn_so && !cyc_super;
    e_e = cyc_done && (m_ext || xfer_err);
    if (wdt_tmo) fw = 1; else if (wok && reg_wdata[11]) fw = 0;
    if (e_r)     fr = 1; else if (wok && reg_wdata[10]) fr = 0;
    if (e_e)     fe = 1; else if (wok && reg_wdata[9])  fe = 0;
    if (e_p)     fp = 1; else if (wok && reg_wdata[8])  fp = 0;
    if (wok) begin
      ew = reg_wdata[3]; er = reg_wdata[2]; ee = reg_wdata[1]; ep = reg_wdata[0];
    end
    if (cyc_done) begin
      m_ext = 0; m_wdt = 0;
    end else if (cyc_active) begin
      if (xfer_err) m_ext = 1;
      if (wdt_tmo)  m_wdt = 1;
    end
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge with inputs already driven
  task automatic tick(input string tag);
    logic [DW-1:0] nxt;
    #1;
    check({tag, " access_err"}, {31'b0, access_err}, {31'b0, model_err()});
    model_update();
    nxt = model_word();
    @(posedge clk); #1;
    check({tag, " reg_rdata"}, reg_rdata, nxt);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc_active = 0; cyc_done = 0; cyc_write = 0; cyc_super = 1;
    rgn_hit = 0; rgn_wo = 0; rgn_so = 0; xfer_err = 0; wdt_tmo = 0;
    reg_wr = 0; reg_super = 0; reg_wdata = '0;
  endtask

  task automatic sup_write(input string tag, input logic [DW-1:0] d);
    idle(); reg_wr = 1; reg_super = 1; reg_wdata = d; tick(tag);
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc_count++;
      if (cyc_count > 150000) begin
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    repeat (3) @(negedge clk);
    check("R1 reset word", reg_rdata, '0);
    rst_n = 1;
    @(negedge clk);

    // R10 enables load
    sup_write("R10 enable all", 32'h0000_000F);
    // R2 read to write-only region, enabled
    idle(); cyc_active = 1; cyc_done = 1; rgn_hit = 1; rgn_wo = 1; tick("R2 read-protect");
    // R3 user access to supervisor-only region
    idle(); cyc_active = 1; cyc_done = 1; rgn_hit = 1; rgn_so = 1; cyc_super = 0; cyc_write = 1;
    tick("R3 privilege");
    // R4 external error mid multi-clock cycle
    idle(); cyc_active = 1; xfer_err = 1; tick("R4 ext mid");
    idle(); cyc_active = 1; tick("R4 ext hold");
    idle(); cyc_active = 1; cyc_done = 1; tick("R4 ext end");
    // R4 external error outside a cycle ignored
    idle(); xfer_err = 1; tick("R4 ext idle");
    // R5 watchdog outside cycle then inside cycle counted at end
    sup_write("R8 clear all", 32'h0000_0F0F);
    idle(); wdt_tmo = 1; tick("R5 wdt idle");
    idle(); cyc_active = 1; wdt_tmo = 1; tick("R5 wdt in cycle");
    idle(); cyc_active = 1; cyc_done = 1; tick("R6 wdt abort at end");
    // R7 enable clear: flag set, no error
    sup_write("R10 enables off", 32'h0000_0F00);
    idle(); cyc_active = 1; cyc_done = 1; rgn_hit = 1; rgn_wo = 1; rgn_so = 1; cyc_super = 0;
    tick("R7 record without abort");
    // R8 writing zero keeps flags
    sup_write("R8 zero write", 32'h0000_0005);
    // R9 event vs clear in same clock
    idle(); wdt_tmo = 1; reg_wr = 1; reg_super = 1; reg_wdata = 32'h0000_0800; tick("R9 event wins");
    // R11 user write ignored
    idle(); reg_wr = 1; reg_super = 0; reg_wdata = 32'hFFFF_FFFF; tick("R11 user write");
    // R1 unused bits on full write
    sup_write("R1 unused bits", 32'hFFFF_F0F0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic act;
      idle();
      act = ($urandom_range(0, 3) != 0);
      cyc_active = act;
      cyc_done   = act && ($urandom_range(0, 2) == 0);
      cyc_write  = $urandom_range(0, 1);
      cyc_super  = $urandom_range(0, 1);
      rgn_hit    = $urandom_range(0, 1);
      rgn_wo     = $urandom_range(0, 1);
      rgn_so     = $urandom_range(0, 1);
      xfer_err   = ($urandom_range(0, 7) == 0);
      wdt_tmo    = ($urandom_range(0, 15) == 0);
      reg_wr     = ($urandom_range(0, 5) == 0);
      reg_super  = ($urandom_range(0, 3) != 0);
      reg_wdata  = $urandom();
      tick("R6 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule